// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block derives the six arithmetic condition flags of an add or subtract: carry, parity, auxiliary carry, zero, sign and overflow. It takes the two operands, the result and an add/subtract select, and it works at a selectable operand width of 8, 16 or 32 bits. Carry and borrow out of the top bit, and out of bit 3, come from the operand and result bits at that position. This means a carry or borrow that entered at bit 0 is taken into account without a separate input.

The flags appear at once on a combinational output, each at its fixed position in a 16-bit status word. A registered copy of that word is also kept. A load control overwrites the whole register. An update control writes only the six arithmetic flags and leaves every other bit of the register as it was.

Top module: `flag_unit`

## Requirements
- R1: Carry (word bit 0) is set when an addition carries out of the top bit of the selected width, or when a subtraction borrows into that bit. A carry or borrow that entered at bit 0 is included.
- R2: Parity (word bit 2) is set when the low 8 bits of the result hold an even number of ones, whatever the width.
- R3: Auxiliary carry (word bit 4) is set on a carry out of bit 3 for addition, or a borrow into bit 3 for subtraction, and is clear otherwise.
- R4: Zero (word bit 6) is set only when every result bit inside the selected width is 0. Result bits above the width are ignored.
- R5: Sign (word bit 7) equals the top result bit of the selected width.
- R6: Overflow (word bit 11) is set for addition when both operands share a sign and the result sign differs. For subtraction it is set when the operand signs differ and the result sign differs from the first operand.
- R7: The width code size_i is 00 for 8 bits, 01 for 16 bits, and 10 or 11 for 32 bits. Operand bits above the selected width have no effect on any flag.
- R8: After reset the registered word reads 0x0002.
- R9: In the registered word, bit 1 always reads 1, and bits 3, 5 and 15 always read 0.
- R10: When upd_i is high and load_i is low, the next edge writes the six arithmetic flags from the combinational output and keeps all other register bits.
- R11: When load_i is high, the next edge writes load_data_i with the fixed bits of R9 applied, whatever upd_i is.
- R12: With load_i and upd_i both low, the registered word holds.
- R13: On the combinational output word, all positions other than the six flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | First operand (minuend for subtraction) |
| op_b_i | input | 32 | Second operand (subtrahend for subtraction) |
| res_i | input | 32 | Result of the operation |
| sub_i | input | 1 | 1 selects subtraction, 0 selects addition |
| size_i | input | 2 | Operand width code |
| upd_i | input | 1 | Write the arithmetic flags into the register |
| load_i | input | 1 | Write the whole register from load_data_i |
| load_data_i | input | 16 | Value written on load |
| flags_now_o | output | 16 | Combinational arithmetic flags at their word positions |
| flags_q_o | output | 16 | Registered status word |

## Verification
The combinational flags follow the inputs in the same cycle. The registered word takes its new value at the first rising edge after the controls are driven. The driver applies each stimulus on a falling edge and queues its expected flags and expected register value. The monitor samples 2 ns after the next rising edge, while the inputs are still held. At that point it compares the combinational flags against the stimulus of that cycle and the register against the value that edge should have written.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
  localparam int CF_POS  = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS  = 2;
  localparam int AF_POS  = 4;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int OF_POS  = 11;
  localparam int RSV_POS = 15;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_WIDE  = 2'b11
  } size_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } arith_flags_t;

  // carry (add) or borrow (sub) out of one bit, recovered from a, b and result
  function automatic logic bit_cy(input logic a, input logic b, input logic r, input logic sub);
    if (sub) return (~a & b) | ((~a | b) & r);
    return (a & b) | ((a | b) & ~r);
  endfunction
endpackage

// File: rtl/flagu_width_sel.sv
module flagu_width_sel #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] r_i,
  input  logic [1:0]    size_i,
  output logic          a_msb_o,
  output logic          b_msb_o,
  output logic          r_msb_o,
  output logic          zero_o
);
  localparam int NSZ = $clog2(DW / 8) + 1;

  logic [NSZ-1:0] lane_a, lane_b, lane_r, lane_z;

  for (genvar i = 0; i < NSZ; i++) begin : g_lane
    localparam int LW = 8 << i;
    assign lane_a[i] = a_i[LW-1];
    assign lane_b[i] = b_i[LW-1];
    assign lane_r[i] = r_i[LW-1];
    assign lane_z[i] = ~|r_i[LW-1:0];
  end

  logic [1:0] sel;
  always_comb begin
    sel = (int'(size_i) > NSZ - 1) ? 2'(NSZ - 1) : size_i;
    a_msb_o = lane_a[sel];
    b_msb_o = lane_b[sel];
    r_msb_o = lane_r[sel];
    zero_o  = lane_z[sel];
  end
endmodule

// File: rtl/flagu_calc.sv
module flagu_calc
  import flagu_pkg::*;
(
  input  logic         sub_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic         r_msb_i,
  input  logic         zero_i,
  input  logic         a3_i,
  input  logic         b3_i,
  input  logic [7:0]   r_lo_i,
  output arith_flags_t flags_o
);
  always_comb begin
    flags_o.cf_f = bit_cy(a_msb_i, b_msb_i, r_msb_i, sub_i);
    flags_o.af_f = bit_cy(a3_i, b3_i, r_lo_i[3], sub_i);
    flags_o.pf_f = ~^r_lo_i;
    flags_o.zf_f = zero_i;
    flags_o.sf_f = r_msb_i;
    flags_o.of_f = sub_i ? ((a_msb_i ^ b_msb_i) & (r_msb_i ^ a_msb_i))
                         : (~(a_msb_i ^ b_msb_i) & (r_msb_i ^ a_msb_i));
  end
endmodule

// File: rtl/flagu_reg.sv
module flagu_reg
  import flagu_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [FW-1:0] load_data_i,
  input  logic          upd_i,
  input  logic [FW-1:0] arith_word_i,
  output logic [FW-1:0] q_o
);
  localparam logic [FW-1:0] ARITH_M = FW'((1 << CF_POS) | (1 << PF_POS) | (1 << AF_POS) |
                                          (1 << ZF_POS) | (1 << SF_POS) | (1 << OF_POS));
  localparam logic [FW-1:0] FIX1_M  = FW'(1 << ONE_POS);
  localparam logic [FW-1:0] FIX0_M  = FW'((1 << 3) | (1 << 5) | (1 << RSV_POS));

  logic [FW-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (load_i)     q_d = (load_data_i & ~FIX0_M) | FIX1_M;
    else if (upd_i) q_d = (q_o & ~ARITH_M) | (arith_word_i & ARITH_M);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= FIX1_M;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flagu_pkg::*;
#(
  parameter int DW = 32,
  parameter int FW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  input  logic [DW-1:0] res_i,
  input  logic          sub_i,
  input  logic [1:0]    size_i,
  input  logic          upd_i,
  input  logic          load_i,
  input  logic [FW-1:0] load_data_i,
  output logic [FW-1:0] flags_now_o,
  output logic [FW-1:0] flags_q_o
);
  logic a_msb, b_msb, r_msb, zero;
  arith_flags_t fl;

  flagu_width_sel #(.DW(DW)) u_wsel (
    .a_i(op_a_i), .b_i(op_b_i), .r_i(res_i), .size_i(size_i),
    .a_msb_o(a_msb), .b_msb_o(b_msb), .r_msb_o(r_msb), .zero_o(zero)
  );

  flagu_calc u_calc (
    .sub_i(sub_i), .a_msb_i(a_msb), .b_msb_i(b_msb), .r_msb_i(r_msb),
    .zero_i(zero), .a3_i(op_a_i[3]), .b3_i(op_b_i[3]), .r_lo_i(res_i[7:0]),
    .flags_o(fl)
  );

  always_comb begin
    flags_now_o = '0;
    flags_now_o[CF_POS] = fl.cf_f;
    flags_now_o[PF_POS] = fl.pf_f;
    flags_now_o[AF_POS] = fl.af_f;
    flags_now_o[ZF_POS] = fl.zf_f;
    flags_now_o[SF_POS] = fl.sf_f;
    flags_now_o[OF_POS] = fl.of_f;
  end

  flagu_reg #(.FW(FW)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_data_i(load_data_i),
    .upd_i(upd_i), .arith_word_i(flags_now_o), .q_o(flags_q_o)
  );
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flagu_pkg::*;
#(
  parameter int DW = 32,
  parameter int FW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] op_a_i,
  input logic [DW-1:0] op_b_i,
  input logic [DW-1:0] res_i,
  input logic          sub_i,
  input logic [1:0]    size_i,
  input logic          upd_i,
  input logic          load_i,
  input logic [FW-1:0] load_data_i,
  input logic [FW-1:0] flags_now_o,
  input logic [FW-1:0] flags_q_o
);
  localparam logic [FW-1:0] ARITH_M = FW'((1 << CF_POS) | (1 << PF_POS) | (1 << AF_POS) |
                                          (1 << ZF_POS) | (1 << SF_POS) | (1 << OF_POS));
  localparam logic [FW-1:0] FIX1_M  = FW'(1 << ONE_POS);
  localparam logic [FW-1:0] FIX0_M  = FW'((1 << 3) | (1 << 5) | (1 << RSV_POS));

  a_r2_parity_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_now_o[PF_POS] == ~^res_i[7:0]);

  a_r5_sign_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == 2'b00 |-> flags_now_o[SF_POS] == res_i[7]);

  a_r4_zero_dword: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i[1] |-> flags_now_o[ZF_POS] == (res_i == '0));

  a_r13_unused_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_now_o & ~ARITH_M) == '0);

  a_r9_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q_o[ONE_POS] && !flags_q_o[3] && !flags_q_o[5] && !flags_q_o[RSV_POS]);

  a_r10_keep_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !load_i |=> (flags_q_o & ~ARITH_M) == ($past(flags_q_o) & ~ARITH_M));

  a_r10_take_arith: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !load_i |=> (flags_q_o & ARITH_M) == ($past(flags_now_o) & ARITH_M));

  a_r11_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> flags_q_o == (($past(load_data_i) & ~FIX0_M) | FIX1_M));

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i && !load_i |=> $stable(flags_q_o));
endmodule

bind flag_unit flag_unit_chk #(.DW(DW), .FW(FW)) u_chk (.*);

// File: tb/tb_flag_unit.sv
module tb_flag_unit;
  localparam int DW = 32;
  localparam int FW = 16;
  localparam logic [15:0] ARITH_M = 16'h08D5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [DW-1:0] op_a_i = '0, op_b_i = '0, res_i = '0;
  logic sub_i = 1'b0, upd_i = 1'b0, load_i = 1'b0;
  logic [1:0] size_i = 2'b00;
  logic [FW-1:0] load_data_i = '0;
  logic [FW-1:0] flags_now_o, flags_q_o;

  always #4 clk_i = ~clk_i;

  flag_unit #(.DW(DW), .FW(FW)) dut (.*);

  typedef struct {
    logic [15:0] ea;
    logic [15:0] er;
  } item_t;

  item_t q_exp[$];
  string q_tag[$];
  int total = 0, bad = 0;
  logic [15:0] model_q = 16'h0002;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_flags(input logic [31:0] a, input logic [31:0] b,
      input logic cin, input logic sub, input logic [1:0] sz, input logic [31:0] r);
    int w;
    logic [32:0] aw, bw, mask;
    logic [15:0] f;
    logic as, bs, rs, cf, af, ofl;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    mask = (33'd1 << w) - 33'd1;
    aw = {1'b0, a} & mask;
    bw = {1'b0, b} & mask;
    as = a[w-1]; bs = b[w-1]; rs = r[w-1];
    if (sub) begin
      cf = aw < (bw + 33'(cin));
      af = {1'b0, a[3:0]} < ({1'b0, b[3:0]} + 5'(cin));
      ofl = (as != bs) && (rs != as);
    end else begin
      cf = ((aw + bw + 33'(cin)) >> w) != 0;
      af = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(cin)) > 5'd15;
      ofl = (as == bs) && (rs != as);
    end
    f = '0;
    f[0] = cf;
    f[2] = ~^r[7:0];
    f[4] = af;
    f[6] = (({1'b0, r} & mask) == 0);
    f[7] = rs;
    f[11] = ofl;
    return f;
  endfunction

  // driver: apply on falling edge, queue expectations
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic cin,
      input logic sub, input logic [1:0] sz, input logic upd, input logic ld,
      input logic [15:0] ldv, input string tag);
    logic [31:0] r;
    item_t it;
    @(negedge clk_i);
    r = sub ? (a - b - 32'(cin)) : (a + b + 32'(cin));
    op_a_i = a; op_b_i = b; res_i = r; sub_i = sub; size_i = sz;
    upd_i = upd; load_i = ld; load_data_i = ldv;
    it.ea = model_flags(a, b, cin, sub, sz, r);
    if (ld)       model_q = (ldv & ~16'h8028) | 16'h0002;
    else if (upd) model_q = (model_q & ~ARITH_M) | it.ea;
    it.er = model_q;
    q_exp.push_back(it);
    q_tag.push_back(tag);
  endtask

  // monitor: 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q_exp.size() > 0) begin
        item_t it;
        string tg;
        it = q_exp.pop_front();
        tg = q_tag.pop_front();
        chk(flags_now_o[0] == it.ea[0], {"R1 carry ", tg}, 32'(flags_now_o), 32'(it.ea));
        chk(flags_now_o[2] == it.ea[2], {"R2 parity ", tg}, 32'(flags_now_o), 32'(it.ea));
        chk(flags_now_o[4] == it.ea[4], {"R3 aux ", tg}, 32'(flags_now_o), 32'(it.ea));
        chk(flags_now_o[6] == it.ea[6], {"R4 zero ", tg}, 32'(flags_now_o), 32'(it.ea));
        chk(flags_now_o[7] == it.ea[7], {"R5 sign ", tg}, 32'(flags_now_o), 32'(it.ea));
        chk(flags_now_o[11] == it.ea[11], {"R6 ovf ", tg}, 32'(flags_now_o), 32'(it.ea));
        chk((flags_now_o & ~ARITH_M) == 16'h0, {"R13 unused ", tg}, 32'(flags_now_o), 32'(it.ea));
        chk(flags_q_o == it.er, {"R9/R10/R11/R12 reg ", tg}, 32'(flags_q_o), 32'(it.er));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk(flags_q_o == 16'h0002, "R8 reset", 32'(flags_q_o), 32'h2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // byte: FF+01 -> CF AF ZF PF
    drive(32'h0000_00FF, 32'h1, 0, 0, 2'b00, 1, 0, 0, "R1 R3 R4 byte wrap");
    drive(32'h0000_007F, 32'h1, 0, 0, 2'b00, 1, 0, 0, "R6 R5 byte ovf");
    drive(32'h0, 32'h1, 0, 1, 2'b00, 1, 0, 0, "R1 R3 byte borrow");
    drive(32'h80, 32'h1, 0, 1, 2'b00, 0, 0, 0, "R6 sub ovf R12 hold");
    drive(32'h8000, 32'h1, 0, 1, 2'b01, 1, 0, 0, "R6 word sub ovf");
    drive(32'hFFFF_FFFF, 32'h1, 0, 0, 2'b10, 1, 0, 0, "R4 dword zero");
    drive(32'h7FFF_FFFF, 32'h0, 1, 0, 2'b11, 1, 0, 0, "R7 code 11 R1 cin");
    drive(32'h5, 32'h5, 1, 1, 2'b10, 1, 0, 0, "R1 borrow in");
    drive(32'hABCD_0100, 32'h1234_FF00, 0, 0, 2'b00, 1, 0, 0, "R7 upper ignored");
    drive(32'h0001_FFFF, 32'h0000_0001, 0, 0, 2'b01, 1, 0, 0, "R4 word zero upper set");
    drive(32'h0, 32'h0, 0, 0, 2'b00, 0, 1, 16'hFFFF, "R11 R9 load ones");
    drive(32'h1, 32'h1, 0, 0, 2'b00, 1, 0, 0, "R10 keep control bits");
    drive(32'hFF, 32'h1, 0, 0, 2'b00, 1, 1, 16'h0000, "R11 load over upd");
    drive(32'h3, 32'h4, 0, 0, 2'b00, 0, 0, 0, "R12 hold");
    drive(32'h0, 32'h0, 0, 0, 2'b00, 0, 1, 16'h0F0F, "R11 load pattern");
    drive(32'h0, 32'h1, 0, 1, 2'b01, 1, 0, 0, "R10 update after load");
    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, 1'($urandom), 1'($urandom), 2'($urandom),
            1'($urandom), ($urandom % 8) == 0, 16'($urandom), "random R1 R2 R3 R6 R7 R10");
    end
    @(negedge clk_i);
    upd_i = 1'b0; load_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #2;
    chk(flags_q_o == model_q, "R12 final hold", 32'(flags_q_o), 32'(model_q));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule